// File: doc/BRIEF.md
# TSF and Beacon Timer Unit

This block keeps a 64-bit time synchronisation counter that counts microseconds. It derives from that counter the events a wireless MAC needs around each beacon. A one-cycle strobe from a microsecond prescaler advances the counter. Software reaches the block through a simple word-wide register port, with one write and one read per cycle.

Software loads the next beacon time in time units, where one time unit is 1024 microseconds. It also sets the beacon period, two alert lead times and an announcement-window length. The block then pulses four event outputs as the counter reaches each target:
- a DMA alert and a software alert ahead of the beacon, compared in eighths of a time unit;
- the beacon itself;
- the end of the announcement window after the beacon.

After each beacon the target moves forward by one period. A miss monitor counts beacon times that pass with no received-beacon strobe. It raises a sticky interrupt status bit that software clears by writing a one to it.

Top module: `tsf_beacon_unit`

## Requirements
- R1: After reset the counter, all targets, the period, the lead times, the CTRL hold bit and the STATUS bit are zero, and all event outputs are low.
- R2: Each cycle with `us_tick` high adds one to the counter. Without a tick the counter holds its value.
- R3: A read of address 1 returns counter bits 63:32 and captures bits 31:0 at the same moment. A later read of address 0 returns the captured lower half, even if the counter has since moved on.
- R4: A write to address 0 only stages a lower half and leaves the counter unchanged. A following write to address 1 loads the full 64 bits {written upper, staged lower} in one step.
- R5: Each write to CTRL (address 5) with bit 0 set toggles a hold state, which reads back as CTRL bit 0. While hold is set, the counter is forced to zero and ticks are ignored. A CTRL write with bit 0 clear has no effect.
- R6: The beacon event pulses for one cycle when a tick moves the counter onto a time-unit boundary whose value (counter bits 41:10) equals the beacon target (address 2). The target then grows by the period (address 3, bits 15:0).
- R7: The DMA alert fires when a tick moves the counter onto an eighth-unit boundary whose value (counter bits 38:7) equals (beacon target − DMA lead) × 8. The software alert uses the software lead in the same way. Address 4 holds the DMA lead in bits 7:0 and the software lead in bits 15:8.
- R8: The window-end event fires at the time unit equal to beacon target + window, where the window is address 4 bits 23:16 and a window of 0 counts as 1. The window-end target is captured when the beacon target is written and again each time a beacon fires, and it reads back at address 8.
- R9: When the number of consecutive beacon events with no `bcn_rx` strobe reaches the threshold (address 7, bits 7:0), STATUS bit 0 (address 6) and `bmiss_irq` are set. `bcn_rx` restarts the count, and a threshold of 0 disables the monitor.
- R10: Writing 1 to STATUS bit 0 clears it. Writing 0 leaves it unchanged.
- R11: Loading the counter directly onto a target boundary produces no event. Events arise only from ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| bcn_rx | input | 1 | Strobe: a beacon was received |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| evt_tbtt | output | 1 | Beacon time pulse |
| evt_dma_alert | output | 1 | DMA beacon alert pulse |
| evt_sw_alert | output | 1 | Software beacon alert pulse |
| evt_atim_end | output | 1 | Announcement window end pulse |
| bmiss_irq | output | 1 | Beacon-miss status bit |

## Verification
A bench model of the counter predicts all four events and the miss bit on every tick cycle. A directed scenario with distinct leads, a zero window and a period of four separates the eighth-unit comparison from the time-unit one. It also shows whether the window-end target follows the beacon that just fired rather than the next one. Random rounds vary the period, leads, window, threshold and sparse `bcn_rx` strobes, which exposes errors in target advance and in how the miss count restarts. Counter loads near the 32-bit carry, a snapshot read with ticks between the two halves, a lower-half-only write and a load placed exactly on a boundary separate the atomic-access and tick-only rules from a plain free-running register.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] A_TSF_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_TSF_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_TBTT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_PERIOD = 4'd3;
  localparam logic [ADDR_W-1:0] A_LEADS  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd6;
  localparam logic [ADDR_W-1:0] A_MISS   = 4'd7;
  localparam logic [ADDR_W-1:0] A_ATIM   = 4'd8;

  typedef struct packed {
    logic [7:0] win;
    logic [7:0] sw_lead;
    logic [7:0] dma_lead;
  } lead_cfg_t;
endpackage

// File: rtl/tbu_tsf_counter.sv
module tbu_tsf_counter #(
  parameter int TSF_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              toggle,
  input  logic              hi_rd,
  input  logic [HALF_W-1:0] wdata,
  output logic [TSF_W-1:0]  tsf,
  output logic [TSF_W-1:0]  tsf_nxt,
  output logic              hold,
  output logic              adv,
  output logic [HALF_W-1:0] snap_lo
);
  logic [HALF_W-1:0] stage_lo;

  assign tsf_nxt = tsf + TSF_W'(1);
  assign adv     = tick && !hold && !hi_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tsf      <= '0;
      hold     <= 1'b0;
      stage_lo <= '0;
      snap_lo  <= '0;
    end else begin
      if (toggle) hold <= ~hold;
      if (lo_wr)  stage_lo <= wdata;
      if (hi_rd)  snap_lo <= tsf[HALF_W-1:0];
      if (hold)       tsf <= '0;
      else if (hi_wr) tsf <= {wdata, stage_lo};
      else if (tick)  tsf <= tsf_nxt;
    end
  end

  // R5: a held counter reads zero
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
    hold |=> (tsf == '0));
  // R2: a counted tick moves by exactly one
  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !hold && !hi_wr) |=> (tsf == $past(tsf) + TSF_W'(1)));
  // R2: without a tick, load or hold the value stays
  p_idle_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hold && !hi_wr) |=> $stable(tsf));
endmodule

// File: rtl/tbu_timers.sv
module tbu_timers #(
  parameter int TSF_W    = 64,
  parameter int CNT_W    = 32,
  parameter int PER_W    = 16,
  parameter int LEAD_W   = 8,
  parameter int TU_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [TSF_W-1:0]  tsf_nxt,
  input  logic              tbtt_wr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [PER_W-1:0]  period,
  input  logic [LEAD_W-1:0] dma_lead,
  input  logic [LEAD_W-1:0] sw_lead,
  input  logic [LEAD_W-1:0] win,
  output logic [CNT_W-1:0]  tgt0,
  output logic [CNT_W-1:0]  atim_tgt,
  output logic              fire_tbtt,
  output logic [3:0]        evt
);
  localparam int E8_SHIFT = TU_SHIFT - 3;
  localparam int NEV      = 4;

  logic [CNT_W-1:0]            tu_val, e8_val, win_eff;
  logic                        tu_edge, e8_edge;
  logic [NEV-1:0][CNT_W-1:0]   cmp_tgt;
  logic [NEV-1:0]              hit;

  assign tu_val  = tsf_nxt[TU_SHIFT +: CNT_W];
  assign e8_val  = tsf_nxt[E8_SHIFT +: CNT_W];
  assign tu_edge = (tsf_nxt[TU_SHIFT-1:0] == '0);
  assign e8_edge = (tsf_nxt[E8_SHIFT-1:0] == '0);
  assign win_eff = (win == '0) ? CNT_W'(1) : CNT_W'(win);

  assign cmp_tgt[0] = tgt0;
  assign cmp_tgt[1] = (tgt0 - CNT_W'(dma_lead)) << 3;
  assign cmp_tgt[2] = (tgt0 - CNT_W'(sw_lead)) << 3;
  assign cmp_tgt[3] = atim_tgt;

  for (genvar g = 0; g < NEV; g++) begin : g_cmp
    if (g == 1 || g == 2) begin : g_eighth
      assign hit[g] = adv && e8_edge && (e8_val == cmp_tgt[g]);
    end else begin : g_unit
      assign hit[g] = adv && tu_edge && (tu_val == cmp_tgt[g]);
    end
  end

  assign fire_tbtt = hit[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt0     <= '0;
      atim_tgt <= '0;
      evt      <= '0;
    end else begin
      evt <= hit;
      if (tbtt_wr) begin
        tgt0     <= wdata;
        atim_tgt <= wdata + win_eff;
      end else if (fire_tbtt) begin
        tgt0     <= tgt0 + CNT_W'(period);
        atim_tgt <= tgt0 + win_eff;
      end
    end
  end

  // R6: the beacon target moves on by one period after it fires
  p_tbtt_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (fire_tbtt && !tbtt_wr) |=> (tgt0 == $past(tgt0) + CNT_W'($past(period))));
  // R6: the beacon event is a single-cycle pulse
  p_tbtt_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    evt[0] |=> !evt[0]);
  // R11: no event without a counted tick in the cycle before
  p_evt_needs_tick_r11: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |-> $past(adv));
endmodule

// File: rtl/tbu_bmiss.sv
module tbu_bmiss #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             bcn_rx,
  input  logic [THR_W-1:0] thr,
  input  logic             clr,
  output logic             flag
);
  logic [THR_W-1:0] cnt;
  logic [THR_W:0]   cnt_inc;
  logic             set;

  assign cnt_inc = {1'b0, cnt} + (THR_W+1)'(1);
  assign set     = fire && !bcn_rx && (thr != '0) && (cnt_inc >= {1'b0, thr});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (bcn_rx)    cnt <= '0;
      else if (set)  cnt <= '0;
      else if (fire) cnt <= cnt_inc[THR_W-1:0];
      if (set)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R9: the threshold being reached raises the status bit
  p_miss_set_r9: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  // R9: the status bit only rises on a beacon event
  p_miss_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(fire));
  // R10: write-one clears when no new miss competes
  p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/tsf_beacon_unit.sv
module tsf_beacon_unit
  import tbu_pkg::*;
#(
  parameter int TSF_W    = 64,
  parameter int PER_W    = 16,
  parameter int TU_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              us_tick,
  input  logic              bcn_rx,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              evt_tbtt,
  output logic              evt_dma_alert,
  output logic              evt_sw_alert,
  output logic              evt_atim_end,
  output logic              bmiss_irq
);
  localparam int THR_W = 8;

  logic [TSF_W-1:0]  tsf, tsf_nxt;
  logic [WORD_W-1:0] snap_lo, tgt0, atim_tgt;
  logic              hold, adv, fire_tbtt;
  logic [3:0]        evt;
  logic [PER_W-1:0]  period;
  lead_cfg_t         leads;
  logic [THR_W-1:0]  thr;

  logic w_lo, w_hi, w_tbtt, w_ctrl, w_stat;
  assign w_lo   = wr_en && (wr_addr == A_TSF_LO);
  assign w_hi   = wr_en && (wr_addr == A_TSF_HI);
  assign w_tbtt = wr_en && (wr_addr == A_TBTT);
  assign w_ctrl = wr_en && (wr_addr == A_CTRL) && wr_data[0];
  assign w_stat = wr_en && (wr_addr == A_STATUS) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
      leads  <= '0;
      thr    <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PERIOD) period <= wr_data[PER_W-1:0];
      if (wr_addr == A_LEADS)  leads  <= wr_data[$bits(lead_cfg_t)-1:0];
      if (wr_addr == A_MISS)   thr    <= wr_data[THR_W-1:0];
    end
  end

  tbu_tsf_counter #(.TSF_W(TSF_W), .HALF_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(us_tick), .lo_wr(w_lo), .hi_wr(w_hi),
    .toggle(w_ctrl), .hi_rd(rd_en && (rd_addr == A_TSF_HI)), .wdata(wr_data),
    .tsf(tsf), .tsf_nxt(tsf_nxt), .hold(hold), .adv(adv), .snap_lo(snap_lo)
  );

  tbu_timers #(.TSF_W(TSF_W), .CNT_W(WORD_W), .PER_W(PER_W), .LEAD_W(8),
               .TU_SHIFT(TU_SHIFT)) u_tmr (
    .clk(clk), .rst(rst), .adv(adv), .tsf_nxt(tsf_nxt), .tbtt_wr(w_tbtt),
    .wdata(wr_data), .period(period), .dma_lead(leads.dma_lead),
    .sw_lead(leads.sw_lead), .win(leads.win), .tgt0(tgt0),
    .atim_tgt(atim_tgt), .fire_tbtt(fire_tbtt), .evt(evt)
  );

  tbu_bmiss #(.THR_W(THR_W)) u_miss (
    .clk(clk), .rst(rst), .fire(fire_tbtt), .bcn_rx(bcn_rx), .thr(thr),
    .clr(w_stat), .flag(bmiss_irq)
  );

  assign evt_tbtt      = evt[0];
  assign evt_dma_alert = evt[1];
  assign evt_sw_alert  = evt[2];
  assign evt_atim_end  = evt[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_TSF_LO: rd_data <= snap_lo;
        A_TSF_HI: rd_data <= tsf[TSF_W-1 -: WORD_W];
        A_TBTT:   rd_data <= tgt0;
        A_PERIOD: rd_data <= WORD_W'(period);
        A_LEADS:  rd_data <= WORD_W'(leads);
        A_CTRL:   rd_data <= WORD_W'(hold);
        A_STATUS: rd_data <= WORD_W'(bmiss_irq);
        A_MISS:   rd_data <= WORD_W'(thr);
        A_ATIM:   rd_data <= atim_tgt;
        default:  rd_data <= '0;
      endcase
    end
  end

  // R4: an upper-half write loads the counter whole
  p_load_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (w_hi && !hold) |=> (tsf[TSF_W-1 -: WORD_W] == $past(wr_data)));
endmodule

// File: tb/tsf_beacon_unit_test.sv
module tsf_beacon_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        us_tick = 1'b0, bcn_rx = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        evt_tbtt, evt_dma_alert, evt_sw_alert, evt_atim_end, bmiss_irq;

  tsf_beacon_unit uut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .bcn_rx(bcn_rx),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_tbtt(evt_tbtt), .evt_dma_alert(evt_dma_alert),
    .evt_sw_alert(evt_sw_alert), .evt_atim_end(evt_atim_end),
    .bmiss_irq(bmiss_irq)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // bench model state
  logic [63:0] m_tsf = '0;
  logic        m_hold = 1'b0;
  logic [31:0] m_t0 = '0, m_atim = '0, m_per = '0;
  logic [7:0]  m_dma = '0, m_sw = '0, m_win = '0, m_thr = '0, m_cnt = '0;
  logic        m_flag = 1'b0;
  logic [3:0]  exp_evt = '0;
  int          seen[4];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] win_eff(input logic [7:0] w);
    return (w == 8'd0) ? 32'd1 : {24'd0, w};
  endfunction

  function automatic logic [3:0] exp_events(input logic [63:0] n);
    logic [31:0] d8, s8;
    logic [3:0]  e;
    d8 = (m_t0 - {24'd0, m_dma}) << 3;
    s8 = (m_t0 - {24'd0, m_sw}) << 3;
    e[0] = (n[9:0] == 0) && (n[41:10] == m_t0);
    e[1] = (n[6:0] == 0) && (n[38:7] == d8);
    e[2] = (n[6:0] == 0) && (n[38:7] == s8);
    e[3] = (n[9:0] == 0) && (n[41:10] == m_atim);
    return e;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic read_tsf(output logic [63:0] v);
    logic [31:0] hi, lo;
    rd(4'd1, hi);
    rd(4'd0, lo);
    v = {hi, lo};
  endtask

  task automatic set_tsf(input logic [63:0] v);
    wr(4'd0, v[31:0]);
    wr(4'd1, v[63:32]);
    if (!m_hold) m_tsf = v;
  endtask

  task automatic set_cfg(input logic [31:0] per, input logic [7:0] d, input logic [7:0] s,
                         input logic [7:0] w, input logic [7:0] thr, input logic [31:0] t0);
    wr(4'd3, per);
    wr(4'd4, {8'd0, w, s, d});
    wr(4'd7, {24'd0, thr});
    wr(4'd2, t0);
    m_per = per; m_dma = d; m_sw = s; m_win = w; m_thr = thr;
    m_t0 = t0; m_atim = t0 + win_eff(w);
  endtask

  // run n tick cycles; events checked every cycle against the model
  task automatic run(input int n, input int rx_per_10k);
    logic rx;
    exp_evt = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R6 R7 R8 events", {evt_atim_end, evt_sw_alert, evt_dma_alert, evt_tbtt}, exp_evt);
      check("R9 miss flag", bmiss_irq, m_flag);
      for (int k = 0; k < 4; k++) if (exp_evt[k]) seen[k]++;
      rx = ($urandom % 10000) < rx_per_10k;
      us_tick = 1'b1; bcn_rx = rx;
      if (!m_hold) begin
        exp_evt = exp_events(m_tsf + 64'd1);
        m_tsf = m_tsf + 64'd1;
        if (rx) m_cnt = '0;
        else if (exp_evt[0]) begin
          if (m_thr != 0 && ({1'b0, m_cnt} + 9'd1) >= {1'b0, m_thr}) begin
            m_flag = 1'b1; m_cnt = '0;
          end else m_cnt = m_cnt + 8'd1;
        end
        if (exp_evt[0]) begin
          m_atim = m_t0 + win_eff(m_win);
          m_t0 = m_t0 + m_per;
        end
      end else begin
        exp_evt = '0;
        if (rx) m_cnt = '0;
      end
    end
    @(negedge clk);
    check("R6 R7 R8 events", {evt_atim_end, evt_sw_alert, evt_dma_alert, evt_tbtt}, exp_evt);
    check("R9 miss flag", bmiss_irq, m_flag);
    for (int k = 0; k < 4; k++) if (exp_evt[k]) seen[k]++;
    us_tick = 1'b0; bcn_rx = 1'b0;
    exp_evt = '0;
  endtask

  initial begin
    #(4 * 195000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] d, hi, lo;
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) seen[k] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 events", {evt_atim_end, evt_sw_alert, evt_dma_alert, evt_tbtt}, 4'd0);
    check("R1 miss", bmiss_irq, 1'b0);
    read_tsf(v);  check("R1 tsf", v, 64'd0);
    rd(4'd5, d);  check("R1 ctrl", d, 32'd0);
    rd(4'd2, d);  check("R1 tbtt", d, 32'd0);
    rd(4'd3, d);  check("R1 period", d, 32'd0);

    // R2 ticking and holding
    run(100, 0);
    read_tsf(v);  check("R2 count", v, 64'd100);
    repeat (10) @(negedge clk);
    read_tsf(v);  check("R2 idle hold", v, 64'd100);

    // R3 carry across halves and snapshot coherence
    set_tsf(64'h1_FFFF_FFF0);
    run(32, 0);
    read_tsf(v);  check("R3 carry", v, 64'h2_0000_0010);
    rd(4'd1, hi);
    run(5, 0);
    rd(4'd0, lo);
    check("R3 snapshot", {hi, lo}, 64'h2_0000_0010);

    // R4 staged lower half does not touch the counter
    wr(4'd0, 32'hDEAD_BEEF);
    read_tsf(v);  check("R4 lo only", v, m_tsf);
    wr(4'd1, 32'h0000_0123);
    m_tsf = 64'h0000_0123_DEAD_BEEF;
    read_tsf(v);  check("R4 atomic load", v, m_tsf);

    // R5 toggling hold
    wr(4'd5, 32'd1); m_hold = 1'b1; m_tsf = '0;
    rd(4'd5, d);  check("R5 hold on", d, 32'd1);
    run(50, 0);
    read_tsf(v);  check("R5 held zero", v, 64'd0);
    wr(4'd5, 32'd0);
    rd(4'd5, d);  check("R5 zero write ignored", d, 32'd1);
    wr(4'd5, 32'd1); m_hold = 1'b0;
    rd(4'd5, d);  check("R5 hold off", d, 32'd0);
    run(7, 0);
    read_tsf(v);  check("R5 restart", v, 64'd7);

    // directed beacon sequence: R6 R7 R8 R9
    set_cfg(32'd4, 8'd2, 8'd1, 8'd0, 8'd2, 32'd12);
    rd(4'd8, d);  check("R8 window zero as one", d, 32'd13);
    set_tsf(64'd10 * 1024 - 3);
    run(7 * 1024 + 10, 0);
    check("R6 beacon count", seen[0], 2);
    check("R7 dma alert count", seen[1], 2);
    check("R7 sw alert count", seen[2], 2);
    check("R8 window end count", seen[3], 2);
    rd(4'd2, d);  check("R6 target advanced", d, 32'd20);
    rd(4'd6, d);  check("R9 status set", d, 32'd1);

    // R10 write-one-to-clear
    wr(4'd6, 32'd0);
    rd(4'd6, d);  check("R10 zero write kept", d, 32'd1);
    wr(4'd6, 32'd1); m_flag = 1'b0;
    rd(4'd6, d);  check("R10 cleared", d, 32'd0);
    check("R10 irq port", bmiss_irq, 1'b0);

    // R11 direct load onto a boundary
    set_cfg(32'd4, 8'd0, 8'd0, 8'd0, 8'd0, 32'd20);
    set_tsf(64'd20 * 1024);
    repeat (3) begin
      @(negedge clk);
      check("R11 no event on load", {evt_atim_end, evt_sw_alert, evt_dma_alert, evt_tbtt}, 4'd0);
    end
    run(64, 0);

    // random rounds
    for (int r = 0; r < 5; r++) begin
      logic [31:0] per, t0;
      logic [7:0]  dl, sl, w, th;
      per = 32'd1 + ($urandom % 4);
      dl = 8'($urandom % 3);
      sl = 8'($urandom % 3);
      w  = 8'($urandom % 4);
      th = 8'($urandom % 3);
      t0 = 32'd8 + ($urandom % 50);
      set_cfg(per, dl, sl, w, th, t0);
      rd(4'd8, d);  check("R8 window target", d, t0 + win_eff(w));
      set_tsf({32'd0, (t0 - 32'd3) * 32'd1024} - 64'($urandom % 20));
      run(int'(per) * 3 * 1024 + 5 * 1024, (r % 2 == 1) ? 3 : 0);
      rd(4'd2, d);  check("R6 random target", d, m_t0);
      rd(4'd8, d);  check("R8 random window target", d, m_atim);
      rd(4'd6, d);  check("R9 random status", d, {31'd0, m_flag});
      read_tsf(v);  check("R2 random count", v, m_tsf);
      wr(4'd6, 32'd1); m_flag = 1'b0;
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule